// File: doc/BRIEF.md
# SD Host Wrapper Register Block

This block is the shared register window that sits in front of one or two SD host slot controllers. It accepts 32-bit reads and writes from a simple single-cycle bus and decodes them into a 256-byte window. The window holds a slot-information word, a debounce setting, per-slot writable shadows of each slot's 64-bit capability word and its maximum-current word, and general storage words such as bus and card-detect/write-protect polarity settings.

The window also holds a live interrupt status word. Each slot's level interrupt input passes through a two-flop synchronizer. The synchronized level shows up as one status bit per slot. The OR of those bits drives a single shared interrupt line. Software reaches each slot's 64-bit capability value through two 32-bit windows, one for the low half and one for the high half, and can override the default that the chip variant supplies as a parameter.

Top module: `sdWrapRegs`

## Requirements
- R1: A write to offset 0x00 (slot information) stores all written bits except bit 0. Bit 0 is a self-clearing reset request and always reads back as 0.
- R2: After reset, offset 0x00 reads 0x00010000 with one slot, or 0x00030000 when NUM_SLOTS is 2. General storage words read 0.
- R3: After reset, offset 0x04 (debounce) reads 0x00000005.
- R4: Slot 0's capability word is at 0x10 (bits 31:0) and 0x14 (bits 63:32), and its max-current word is at 0x18. All three are readable and writable. The capability word resets to the CAP_RESET parameter and the max-current word resets to 0.
- R5: Slot 1 uses 0x20, 0x24 and 0x28 with the same layout. A write to either slot's offsets changes only that slot's storage.
- R6: Offset 0xFC reads bit n as the synchronized level of slotIrq[n], two clock edges after the input changes. Writes to 0xFC have no effect.
- R7: irqOut is high exactly when at least one bit of the interrupt status is high.
- R8: Every other word offset below 0x100, including 0x08, 0xEC and 0xF0, is plain 32-bit read/write storage.
- R9: An access at or above 0x100, or with address bits [1:0] not zero, reads 0 and ignores the write. It raises busErr for exactly the one cycle after the request.
- R10: Read data appears on busRdata at the clock edge after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle pulse for an out-of-window or misaligned access |
| slotIrq | input | NUM_SLOTS | Level interrupt from each slot controller |
| irqOut | output | 1 | Shared interrupt line |

## Verification
The embedded properties run on every cycle. They check that the error pulse follows any out-of-window request and drops when the bus is idle, that out-of-window reads and slot-information reads return zeros where required, and that a rising shared interrupt always traces back to a slot input two edges earlier. Only the bench scenarios can show the stored values and reset defaults of each offset. The same is true of the isolation between the two slots' shadows, the ignored writes to the status word and to aliased out-of-window addresses, and the exact status-bit patterns as the slot inputs change.

// File: rtl/sdWrapPkg.sv
package sdWrapPkg;
  localparam int WIN_BYTES  = 256;
  localparam int WIN_WORDS  = WIN_BYTES / 4;
  localparam int WORD_W     = $clog2(WIN_WORDS);
  localparam int GRP_W      = WORD_W - 2;
  localparam int MAX_SLOTS  = 2;
  localparam int INFO_WORD  = 0;
  localparam int DEB_WORD   = 1;
  localparam int STAT_WORD  = WIN_WORDS - 1;
  localparam logic [31:0] DEB_RESET = 32'h0000_0005;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              hit;
    logic [WORD_W-1:0] word;
  } busStrobe_t;
endpackage

// File: rtl/sdWrapCtrl.sv
module sdWrapCtrl
  import sdWrapPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe,
  output logic              busErr
);
  logic inWindow;

  always_comb begin
    inWindow    = (busAddr < ADDR_W'(WIN_BYTES)) && (busAddr[1:0] == 2'b00);
    strobe.rd   = busValid && !busWrite;
    strobe.wr   = busValid && busWrite;
    strobe.hit  = inWindow;
    strobe.word = busAddr[WORD_W+1:2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= busValid && !inWindow;
  end

  // R9: any request outside the window is flagged on the next cycle
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr >= ADDR_W'(WIN_BYTES)) |=> busErr);
  // R9: an idle bus never leaves the error flag raised
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !busErr);
endmodule

// File: rtl/sdWrapData.sv
module sdWrapData
  import sdWrapPkg::*;
#(
  parameter int          NUM_SLOTS = 2,
  parameter logic [63:0] CAP_RESET = 64'h0000_0007_01F8_0080
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [31:0]          busWdata,
  input  logic [NUM_SLOTS-1:0] slotIrq,
  output logic [31:0]          busRdata,
  output logic                 irqOut
);
  localparam logic [31:0] INFO_RESET =
    32'h0001_0000 | ((NUM_SLOTS == 2) ? 32'h0002_0000 : 32'h0);

  logic [31:0]          plainMem [WIN_WORDS];
  logic [NUM_SLOTS-1:0] irqMeta, irqStat;
  logic [GRP_W-1:0]     grp;
  logic [1:0]           field;
  logic                 slotOwned;
  logic [NUM_SLOTS-1:0] slotHit;
  logic [31:0]          slotRd [NUM_SLOTS];
  logic [31:0]          rdMux;

  always_comb begin
    grp       = strobe.word[WORD_W-1:2];
    field     = strobe.word[1:0];
    slotOwned = (grp != '0) && (int'(grp) <= NUM_SLOTS) && (field != 2'd3);
  end

  // Per-slot capability and max-current shadows
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [63:0] capReg;
    logic [31:0] curReg;
    assign slotHit[s] = slotOwned && (grp == GRP_W'(s + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capReg <= CAP_RESET;
        curReg <= '0;
      end else if (strobe.wr && strobe.hit && slotHit[s]) begin
        case (field)
          2'd0:    capReg[31:0]  <= busWdata;
          2'd1:    capReg[63:32] <= busWdata;
          default: curReg        <= busWdata;
        endcase
      end
    end

    always_comb begin
      case (field)
        2'd0:    slotRd[s] = capReg[31:0];
        2'd1:    slotRd[s] = capReg[63:32];
        default: slotRd[s] = curReg;
      endcase
    end
  end

  // Plain storage, slot-info and debounce words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WIN_WORDS; i++) begin
        if (i == INFO_WORD)     plainMem[i] <= INFO_RESET;
        else if (i == DEB_WORD) plainMem[i] <= DEB_RESET;
        else                    plainMem[i] <= '0;
      end
    end else if (strobe.wr && strobe.hit && !slotOwned &&
                 strobe.word != WORD_W'(STAT_WORD)) begin
      if (strobe.word == WORD_W'(INFO_WORD))
        plainMem[strobe.word] <= busWdata & ~32'h1;
      else
        plainMem[strobe.word] <= busWdata;
    end
  end

  // Interrupt synchronizer and shared line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqMeta <= '0;
      irqStat <= '0;
    end else begin
      irqMeta <= slotIrq;
      irqStat <= irqMeta;
    end
  end
  assign irqOut = |irqStat;

  always_comb begin
    rdMux = '0;
    if (!strobe.hit)                             rdMux = '0;
    else if (slotOwned) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (slotHit[s]) rdMux = slotRd[s];
    end
    else if (strobe.word == WORD_W'(STAT_WORD)) rdMux = 32'(irqStat);
    else                                         rdMux = plainMem[strobe.word];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busRdata <= '0;
    else if (strobe.rd) busRdata <= rdMux;
  end

  // R1: the reset-request bit never reads back set
  p_info_clr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rd && strobe.hit && strobe.word == WORD_W'(INFO_WORD)) |=> !busRdata[0]);
  // R9: reads outside the window return zero
  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rd && !strobe.hit) |=> (busRdata == 32'h0));
endmodule

// File: rtl/sdWrapRegs.sv
module sdWrapRegs
  import sdWrapPkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          NUM_SLOTS = 2,
  parameter logic [63:0] CAP_RESET = 64'h0000_0007_01F8_0080
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 busErr,
  input  logic [NUM_SLOTS-1:0] slotIrq,
  output logic                 irqOut
);
  busStrobe_t strobe;

  sdWrapCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe), .busErr(busErr)
  );

  sdWrapData #(.NUM_SLOTS(NUM_SLOTS), .CAP_RESET(CAP_RESET)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .slotIrq(slotIrq), .busRdata(busRdata), .irqOut(irqOut)
  );

  // R7/R6: a rising shared line comes from a slot input seen two edges earlier
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|slotIrq, 2));
endmodule

// File: tb/sdWrapRegs_test.sv
`timescale 1ns/1ps
module sdWrapRegs_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        busValid = 0, busWrite = 0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic [1:0]  slotIrq = '0;
  logic        irqOut;

  int runCnt = 0, failCnt = 0;

  typedef struct {
    bit          isRd;
    logic [31:0] exp;
    logic        expErr;
    string       tag;
  } item_t;
  item_t sbq[$];

  sdWrapRegs uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .slotIrq(slotIrq), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per bus access
  always @(posedge clk) begin
    if (rstN && busValid) begin
      item_t it;
      #1;
      if (sbq.size() == 0) begin
        check(1'b0, "scoreboard empty", 0, 0);
      end else begin
        it = sbq.pop_front();
        check(busErr === it.expErr, {it.tag, " err"}, 32'(busErr), 32'(it.expErr));
        if (it.isRd)
          check(busRdata === it.exp, {it.tag, " data"}, busRdata, it.exp);
      end
    end
  end

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input logic expErr, input string tag);
    item_t it;
    @(negedge clk);
    busValid = 1; busWrite = wr; busAddr = a; busWdata = d;
    it.isRd = !wr; it.exp = exp; it.expErr = expErr; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic e, input string tag);
    access(1'b1, a, d, '0, e, tag);
  endtask
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input logic e, input string tag);
    access(1'b0, a, '0, exp, e, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++; runCnt++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busRdata === 0 && busErr === 0 && irqOut === 0, "R2 outputs in reset", busRdata, 0);
    rstN = 1;
    // reset values
    rd(12'h000, 32'h0003_0000, 0, "R2 info reset");
    rd(12'h004, 32'h0000_0005, 0, "R3 debounce reset");
    rd(12'h008, 32'h0, 0, "R2 plain reset");
    rd(12'h010, 32'h01F8_0080, 0, "R4 cap0 lo reset");
    rd(12'h014, 32'h0000_0007, 0, "R4 cap0 hi reset");
    rd(12'h018, 32'h0, 0, "R4 cur0 reset");
    rd(12'h020, 32'h01F8_0080, 0, "R5 cap1 lo reset");
    rd(12'h024, 32'h0000_0007, 0, "R5 cap1 hi reset");
    rd(12'h0FC, 32'h0, 0, "R6 stat reset");
    // R10: data holds through idle cycles
    repeat (2) @(negedge clk);
    check(busRdata === 0 && busErr === 0, "R10 hold after read", busRdata, 0);
    // R1
    wr(12'h000, 32'hA5A5_0003, 0, "R1 info write");
    rd(12'h000, 32'hA5A5_0002, 0, "R1 info readback");
    // R4 / R5
    wr(12'h010, 32'h1111_2222, 0, "R4 cap0 lo write");
    wr(12'h014, 32'h3333_4444, 0, "R4 cap0 hi write");
    wr(12'h018, 32'h5555_6666, 0, "R4 cur0 write");
    wr(12'h028, 32'h7777_8888, 0, "R5 cur1 write");
    rd(12'h018, 32'h5555_6666, 0, "R5 cur0 untouched by slot1");
    rd(12'h028, 32'h7777_8888, 0, "R5 cur1 readback");
    rd(12'h010, 32'h1111_2222, 0, "R4 cap0 lo readback");
    rd(12'h014, 32'h3333_4444, 0, "R4 cap0 hi readback");
    rd(12'h020, 32'h01F8_0080, 0, "R5 cap1 untouched by slot0");
    wr(12'h024, 32'h9999_AAAA, 0, "R5 cap1 hi write");
    rd(12'h014, 32'h3333_4444, 0, "R5 cap0 hi untouched");
    rd(12'h024, 32'h9999_AAAA, 0, "R5 cap1 hi readback");
    // R8
    wr(12'h008, 32'hDEAD_BEEF, 0, "R8 0x08 write");
    wr(12'h0EC, 32'h0000_0001, 0, "R8 0xEC write");
    wr(12'h0F0, 32'h0000_0002, 0, "R8 0xF0 write");
    wr(12'h004, 32'h0000_00C3, 0, "R8 debounce write");
    rd(12'h008, 32'hDEAD_BEEF, 0, "R8 0x08 readback");
    rd(12'h0EC, 32'h0000_0001, 0, "R8 0xEC readback");
    rd(12'h0F0, 32'h0000_0002, 0, "R8 0xF0 readback");
    rd(12'h004, 32'h0000_00C3, 0, "R8 debounce readback");
    // R9
    wr(12'h108, 32'hFFFF_FFFF, 1, "R9 oob write");
    rd(12'h008, 32'hDEAD_BEEF, 0, "R9 oob write ignored");
    rd(12'h100, 32'h0, 1, "R9 oob read");
    @(negedge clk);
    check(busErr === 0, "R9 error lasts one cycle", 32'(busErr), 0);
    wr(12'h00A, 32'h1234_5678, 1, "R9 misaligned write");
    rd(12'h009, 32'h0, 1, "R9 misaligned read");
    rd(12'h008, 32'hDEAD_BEEF, 0, "R9 misaligned write ignored");
    // R6 / R7
    @(negedge clk); slotIrq = 2'b10;
    @(negedge clk);
    check(irqOut === 0, "R6 sync latency", 32'(irqOut), 0);
    repeat (2) @(negedge clk);
    check(irqOut === 1, "R7 slot1 raises line", 32'(irqOut), 1);
    rd(12'h0FC, 32'h2, 0, "R6 stat slot1");
    wr(12'h0FC, 32'h0, 0, "R6 stat write");
    rd(12'h0FC, 32'h2, 0, "R6 stat write ignored");
    slotIrq = 2'b11;
    repeat (3) @(negedge clk);
    rd(12'h0FC, 32'h3, 0, "R6 stat both");
    slotIrq = 2'b01;
    repeat (3) @(negedge clk);
    check(irqOut === 1, "R7 slot0 keeps line", 32'(irqOut), 1);
    rd(12'h0FC, 32'h1, 0, "R6 stat slot0");
    slotIrq = 2'b00;
    repeat (3) @(negedge clk);
    check(irqOut === 0, "R7 line drops", 32'(irqOut), 0);
    rd(12'h0FC, 32'h0, 0, "R6 stat clear");
    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "scoreboard drained", 32'(sbq.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule